// File: doc/BRIEF.md
# ADC Hardware Trigger Arbiter

This block is the digital front end that decides when an analog-to-digital conversion begins under hardware triggering, and which of several status/control register sets that conversion uses. An asynchronous trigger line is brought into the clock domain through a synchronizer. A conversion is launched on its rising edge only when triggering is enabled, no conversion is running, and exactly one of a group of select lines is high at that moment. The high select line names the register set, and its index is presented on an output for the rest of the converter.

In single mode every qualifying edge gives one conversion. In continuous mode the first qualifying edge latches the register set, and the block relaunches a conversion every time the converter reports completion, until an abort arrives. More than one select line high at a trigger edge is an illegal request. It starts nothing and raises an error pulse. The converter itself is outside the block. It sees a start pulse and answers with a done pulse.

Top module: `adc_trig_arbiter`

## Requirements
- R1: A conversion start (`conv_start_o` high for exactly one cycle) happens only on a rising edge of `trig_async_i` while `trig_en_i` is 1. The pulse is visible after the third rising clock edge following the trigger's rise: two synchronizer stages plus one output register.
- R2: The rising edge counts only if exactly one bit of `trig_sel_i` is 1 in the cycle the edge is detected. An edge seen with no select bit high is ignored, and so is a select that was high earlier but dropped before the edge.
- R3: `set_idx_o` carries the binary position of the select bit that was high at the triggering edge (bit i gives index i). It stays unchanged for as long as `busy_o` remains high.
- R4: A rising edge that arrives while `busy_o` is 1 starts nothing, raises no error and leaves `set_idx_o` unchanged.
- R5: If `cont_mode_i` was 1 at the triggering edge, each `conv_done_i` pulse seen while busy gives a new start pulse on the next cycle with the same index, and `busy_o` stays high. `cont_mode_i` is latched at the edge, so later changes to it have no effect.
- R6: In single mode a `conv_done_i` pulse seen while busy drops `busy_o` on the next cycle. A done pulse that coincides with the start pulse is ignored.
- R7: If two or more select bits are high at a qualifying edge, no conversion starts and `sel_err_o` is 1 for exactly one cycle.
- R8: `abort_i` clears `busy_o` and the continuous latch on the next clock edge, with no start pulse. Abort wins over a done pulse or an edge in the same cycle. Conversions restart only on a fresh qualifying edge.
- R9: Clearing `trig_en_i` has no effect on a conversion in progress or on continuous relaunches. It only blocks future edges.
- R10: While `rst` is high (synchronous, active high) and after it, until the first start, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_en_i | input | 1 | Enables hardware triggering for new edges |
| trig_async_i | input | 1 | Asynchronous hardware trigger line |
| trig_sel_i | input | 4 | One bit per register set; exactly one must be high at a trigger |
| cont_mode_i | input | 1 | Continuous mode, latched at the triggering edge |
| abort_i | input | 1 | Stops the running conversion and continuous repetition |
| conv_done_i | input | 1 | Completion pulse from the converter |
| conv_start_o | output | 1 | Single-cycle conversion start |
| set_idx_o | output | 2 | Index of the register set in use |
| busy_o | output | 1 | A conversion or continuous sequence is active |
| sel_err_o | output | 1 | One-cycle pulse on an illegal multi-select trigger |

## Verification
The assertions assume that `trig_sel_i`, `trig_en_i`, `cont_mode_i`, `abort_i` and `conv_done_i` are synchronous to `clk`, and that the converter pulses done only for a conversion it was started on. The stimulus changes every input on the falling clock edge. The done stub pulses only after it has seen a start, with a latency of one to six cycles. The random select patterns deliberately include empty and multi-bit values, so that the error and ignore paths are exercised alongside legal one-hot requests.

// File: rtl/adc_trig_pkg.sv
`timescale 1ns/1ps
package adc_trig_pkg;
  typedef enum logic [0:0] {
    CTL_IDLE = 1'b0,
    CTL_BUSY = 1'b1
  } ctl_state_e;

  typedef struct packed {
    logic one;   // exactly one select high
    logic many;  // two or more selects high
  } sel_class_t;
endpackage

// File: rtl/trig_edge_sync.sv
`timescale 1ns/1ps
module trig_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_async,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], trig_async};
      last_q  <= chain_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R1
endmodule

// File: rtl/sel_decode.sv
`timescale 1ns/1ps
module sel_decode
  import adc_trig_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int IDX_W    = 2
) (
  input  logic [NUM_SETS-1:0] sel_i,
  output sel_class_t          cls_o,
  output logic [IDX_W-1:0]    idx_o
);
  localparam int CNT_W = $clog2(NUM_SETS + 1);

  // Each index bit is the OR of the select lines whose position has that bit set.
  for (genvar b = 0; b < IDX_W; b++) begin : g_idx_bit
    logic [NUM_SETS-1:0] mask;
    for (genvar i = 0; i < NUM_SETS; i++) begin : g_mask
      assign mask[i] = ((i >> b) & 1) == 1;
    end
    assign idx_o[b] = |(sel_i & mask);
  end

  logic [CNT_W-1:0] ones;
  always_comb begin
    ones = '0;
    for (int i = 0; i < NUM_SETS; i++) begin
      ones = ones + CNT_W'(sel_i[i]);
    end
    cls_o.one  = (ones == CNT_W'(1));
    cls_o.many = (ones > CNT_W'(1));
  end

  always_comb begin
    if (cls_o.one) begin
      AST_IDX_MATCH: assert (sel_i[idx_o]); // R3
    end
  end
endmodule

// File: rtl/conv_ctrl.sv
`timescale 1ns/1ps
module conv_ctrl
  import adc_trig_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             en_i,
  input  logic             cont_i,
  input  logic             abort_i,
  input  logic             done_i,
  input  sel_class_t       cls_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             start_o,
  output logic [IDX_W-1:0] set_idx_o,
  output logic             busy_o,
  output logic             err_o
);
  ctl_state_e       state_q;
  logic             cont_q;
  logic             start_q;
  logic             err_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CTL_IDLE;
      cont_q  <= 1'b0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      start_q <= 1'b0;
      err_q   <= 1'b0;
      if (abort_i) begin
        state_q <= CTL_IDLE;
        cont_q  <= 1'b0;
      end else if (state_q == CTL_BUSY) begin
        if (done_i && !start_q) begin
          if (cont_q) start_q <= 1'b1;
          else        state_q <= CTL_IDLE;
        end
      end else if (rise_i && en_i) begin
        if (cls_i.one) begin
          state_q <= CTL_BUSY;
          start_q <= 1'b1;
          idx_q   <= idx_i;
          cont_q  <= cont_i;
        end else if (cls_i.many) begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign start_o   = start_q;
  assign err_o     = err_q;
  assign set_idx_o = idx_q;
  assign busy_o    = (state_q == CTL_BUSY);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o); // R1
  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (start_o && !$past(busy_o)) |-> $past(rise_i && en_i && cls_i.one && !abort_i)); // R2
  AST_IDX_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(set_idx_o)); // R3
  AST_BUSY_IGNORES_EDGE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_i && !abort_i) |=> (busy_o && !err_o && !start_o)); // R4
  AST_CONT_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
    (busy_o && done_i && !start_o && cont_q && !abort_i) |=> (start_o && busy_o)); // R5
  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && done_i && !start_o && !cont_q && !abort_i) |=> !busy_o); // R6
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!start_o && !busy_o)); // R7
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o); // R7
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!busy_o && !start_o && !cont_q)); // R8
endmodule

// File: rtl/adc_trig_arbiter.sv
`timescale 1ns/1ps
module adc_trig_arbiter
  import adc_trig_pkg::*;
#(
  parameter int NUM_SETS    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig_en_i,
  input  logic                trig_async_i,
  input  logic [NUM_SETS-1:0] trig_sel_i,
  input  logic                cont_mode_i,
  input  logic                abort_i,
  input  logic                conv_done_i,
  output logic                conv_start_o,
  output logic [IDX_W-1:0]    set_idx_o,
  output logic                busy_o,
  output logic                sel_err_o
);
  logic             rise;
  sel_class_t       cls;
  logic [IDX_W-1:0] idx;

  trig_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .trig_async (trig_async_i),
    .rise_o     (rise)
  );

  sel_decode #(.NUM_SETS(NUM_SETS), .IDX_W(IDX_W)) u_dec (
    .sel_i (trig_sel_i),
    .cls_o (cls),
    .idx_o (idx)
  );

  conv_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise),
    .en_i      (trig_en_i),
    .cont_i    (cont_mode_i),
    .abort_i   (abort_i),
    .done_i    (conv_done_i),
    .cls_i     (cls),
    .idx_i     (idx),
    .start_o   (conv_start_o),
    .set_idx_o (set_idx_o),
    .busy_o    (busy_o),
    .err_o     (sel_err_o)
  );
endmodule

// File: tb/tb_adc_trig_arbiter.sv
`timescale 1ns/1ps
module tb_adc_trig_arbiter;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_en_i = 1'b0, trig_async_i = 1'b0, cont_mode_i = 1'b0;
  logic abort_i = 1'b0, conv_done_i = 1'b0;
  logic [NS-1:0] trig_sel_i = '0;
  logic conv_start_o, busy_o, sel_err_o;
  logic [1:0] set_idx_o;

  adc_trig_arbiter #(.NUM_SETS(NS), .SYNC_STAGES(2)) dut (.*);

  always #4 clk = ~clk; // 125 MHz

  int checks = 0, fails = 0, starts = 0;
  bit finished = 0;

  // expected-value model, driven by the requirements
  logic m_s1, m_s2, m_last, m_busy, m_cont, m_start, m_err;
  logic [1:0] m_idx;

  function automatic int ones4(logic [NS-1:0] v);
    int c = 0;
    for (int i = 0; i < NS; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [1:0] pos4(logic [NS-1:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return 2'(i);
    return 2'd0;
  endfunction

  always @(posedge clk) begin
    logic edge_seen, ns, ne;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_last = 0; m_busy = 0; m_cont = 0;
      m_start = 0; m_err = 0; m_idx = 0;
    end else begin
      edge_seen = m_s2 & ~m_last;
      m_last = m_s2; m_s2 = m_s1; m_s1 = trig_async_i;
      ns = 0; ne = 0;
      if (abort_i) begin
        m_busy = 0; m_cont = 0;
      end else if (m_busy) begin
        if (conv_done_i && !m_start) begin
          if (m_cont) ns = 1; else m_busy = 0;
        end
      end else if (edge_seen && trig_en_i) begin
        if (ones4(trig_sel_i) == 1) begin
          ns = 1; m_busy = 1; m_idx = pos4(trig_sel_i); m_cont = cont_mode_i;
        end else if (ones4(trig_sel_i) > 1) ne = 1;
      end
      m_start = ns; m_err = ne;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // done stub
  bit stub_on = 1;
  int lat = 4, cnt = 0;

  task automatic tick();
    @(negedge clk);
    check(conv_start_o == m_start, "R1 start_o", int'(conv_start_o), int'(m_start));
    check(set_idx_o == m_idx, "R3 set_idx_o", int'(set_idx_o), int'(m_idx));
    check(busy_o == m_busy, "R6 busy_o", int'(busy_o), int'(m_busy));
    check(sel_err_o == m_err, "R7 sel_err_o", int'(sel_err_o), int'(m_err));
    if (conv_start_o) starts++;
    conv_done_i = 0;
    if (m_start) cnt = lat;
    else if (stub_on && m_busy && cnt > 0) begin
      cnt--;
      if (cnt == 0) conv_done_i = 1;
    end
  endtask

  task automatic fire();
    trig_async_i = 0;
    repeat (3) tick();
    trig_async_i = 1;
    repeat (3) tick();
  endtask

  initial begin
    int s0;
    void'($urandom(32'h5eed_c0de));
    repeat (3) tick();
    check(!conv_start_o && !busy_o && !sel_err_o && set_idx_o == 0, "R10 reset outputs",
          int'({conv_start_o, busy_o, sel_err_o}), 0);
    rst = 0;
    tick();
    check(!busy_o && !conv_start_o, "R10 after reset", int'(busy_o), 0);

    // R1/R3: single trigger on set 1
    trig_en_i = 1; trig_sel_i = 4'b0010;
    trig_async_i = 0; repeat (3) tick();
    trig_async_i = 1; tick(); tick();
    check(conv_start_o == 0, "R1 no start before 3rd edge", int'(conv_start_o), 0);
    tick();
    check(conv_start_o == 1, "R1 start on 3rd edge", int'(conv_start_o), 1);
    check(set_idx_o == 2'd1, "R3 index of set 1", int'(set_idx_o), 1);
    tick();
    check(conv_start_o == 0, "R1 start is one cycle", int'(conv_start_o), 0);
    repeat (10) tick();
    check(busy_o == 0, "R6 single mode releases busy", int'(busy_o), 0);

    // R1: enable low blocks the edge
    trig_en_i = 0; s0 = starts; fire(); repeat (3) tick();
    check(starts == s0 && !busy_o, "R1 disabled edge ignored", starts - s0, 0);
    trig_en_i = 1;

    // R2: no select, and select dropped before the edge
    trig_sel_i = 0; s0 = starts; fire(); repeat (3) tick();
    check(starts == s0 && !busy_o, "R2 edge without select", starts - s0, 0);
    trig_sel_i = 4'b0010; tick(); trig_sel_i = 0;
    s0 = starts; fire(); repeat (3) tick();
    check(starts == s0 && !busy_o, "R2 select dropped before edge", starts - s0, 0);

    // R7: two selects at once
    trig_sel_i = 4'b0101; fire();
    check(sel_err_o == 1 && conv_start_o == 0, "R7 multi select error", int'(sel_err_o), 1);
    tick();
    check(sel_err_o == 0 && busy_o == 0, "R7 error is one cycle", int'(sel_err_o), 0);

    // R4: edge while busy is ignored
    stub_on = 0; trig_sel_i = 4'b0100; fire();
    check(conv_start_o == 1 && set_idx_o == 2'd2, "R3 index of set 2", int'(set_idx_o), 2);
    trig_sel_i = 4'b0001; s0 = starts; fire(); repeat (2) tick();
    check(starts == s0 && set_idx_o == 2'd2 && busy_o && !sel_err_o,
          "R4 busy edge ignored", int'(set_idx_o), 2);
    stub_on = 1; repeat (12) tick();
    check(busy_o == 0, "R6 release after done", int'(busy_o), 0);

    // R5/R9/R8: continuous run, enable cleared, then abort
    cont_mode_i = 1; trig_sel_i = 4'b1000; fire();
    cont_mode_i = 0; s0 = starts; repeat (30) tick();
    check(starts - s0 >= 3 && set_idx_o == 2'd3 && busy_o, "R5 continuous relaunch",
          starts - s0, 3);
    trig_en_i = 0; s0 = starts; repeat (20) tick();
    check(starts - s0 >= 2 && busy_o, "R9 enable clear keeps running", starts - s0, 2);
    abort_i = 1; tick(); abort_i = 0; tick();
    check(busy_o == 0 && conv_start_o == 0, "R8 abort clears busy", int'(busy_o), 0);
    s0 = starts; repeat (20) tick();
    check(starts == s0 && !busy_o, "R8 no restart after abort", starts - s0, 0);
    trig_en_i = 1; trig_sel_i = 4'b0001; fire();
    check(conv_start_o == 1 && set_idx_o == 2'd0, "R8 fresh edge restarts", int'(conv_start_o), 1);
    repeat (12) tick();

    // random phase
    for (int n = 0; n < 6000; n++) begin
      tick();
      abort_i = ($urandom % 60) == 0;
      if ($urandom % 5 == 0) trig_async_i = ~trig_async_i;
      if ($urandom % 8 == 0) begin
        case ($urandom % 8)
          0: trig_sel_i = 0;
          1: trig_sel_i = 4'b0011 << ($urandom % 3);
          default: trig_sel_i = 4'b0001 << ($urandom % 4);
        endcase
      end
      if ($urandom % 20 == 0) trig_en_i = ($urandom % 5) != 0;
      if ($urandom % 10 == 0) cont_mode_i = ($urandom % 3) == 0;
      lat = 1 + int'($urandom % 6);
    end
    abort_i = 0; repeat (4) tick();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule